// File: doc/BRIEF.md
# Dual-Half RAM Bank Mapper

This block places a 512KB RAM behind a CPU that can address only 64KB. The RAM is treated as sixteen 32KB banks. The CPU's address space is split into a lower half and an upper half, and each half can show any one of the sixteen banks. The choice is held in a single 8-bit bank register. Its low nibble picks the bank seen in the lower half and its high nibble picks the bank seen in the upper half. Writing 10H therefore shows the first 64KB of RAM in order.

Software loads the register with an I/O write to any address from 70H to 7FH. All sixteen of those addresses reach the same register. The register cannot be read, so software must keep its own copy of the value. The block has no data output at all, which means an I/O read of the range leaves the data bus undriven.

The I/O write strobe (IORQ low together with WR low) is passed through a two-stage synchroniser. A small state machine then turns its rising edge into a single load pulse. The machine has three states:
- ST_IDLE: waiting for the strobe. It moves to ST_LOAD when the synchronised strobe goes high.
- ST_LOAD: one cycle that issues the load pulse. It moves to ST_HOLD if the strobe is still high, or back to ST_IDLE if it has gone low.
- ST_HOLD: waiting for the strobe to be released. It returns to ST_IDLE when the strobe goes low.

The bank register has no reset and holds an unknown value until its first load. The address translation and the memory strobes to the RAM are purely combinational.

Top module: `bank_mapper`

## Requirements
- R1: The physical address bits ram_addr[14:0] always equal cpu_addr[14:0].
- R2: When cpu_addr[15] is 0, ram_addr[18:15] equals bank register bits 3:0.
- R3: When cpu_addr[15] is 1, ram_addr[18:15] equals bank register bits 7:4.
- R4: An I/O write (iorq_n=0 and io_wr_n=0) loads io_data into the bank register when io_addr[7:4] is 7H. This holds for every address from 70H to 7FH. The new mapping is visible no later than the fourth rising clock edge after the strobe is asserted.
- R5: An I/O write to an address outside 70H-7FH, for example 6FH or 80H, leaves the bank register unchanged.
- R6: An I/O cycle with io_wr_n high (a read) does not load the register. The block has no data output, so it never drives the data bus.
- R7: After writing 10H, ram_addr equals {3'b000, cpu_addr} for every CPU address.
- R8: One write strobe loads the register exactly once. If io_data changes while the strobe is still held after the load, the register keeps the value that was loaded first.
- R9: ram_ce_n equals mreq_n. ram_oe_n is low only when mreq_n and mem_rd_n are both low. ram_we_n is low only when mreq_n and mem_wr_n are both low.
- R10: rst_n only returns the strobe state machine to ST_IDLE. It does not clear the bank register. An I/O write strobe seen while rst_n is low does not load the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset for the strobe logic |
| iorq_n | input | 1 | CPU I/O request, active low |
| io_wr_n | input | 1 | CPU write strobe for I/O cycles, active low |
| io_addr | input | 8 | Low byte of the I/O port address |
| io_data | input | 8 | CPU data bus, sampled on a bank write |
| mreq_n | input | 1 | CPU memory request, active low |
| mem_rd_n | input | 1 | CPU read strobe, active low |
| mem_wr_n | input | 1 | CPU write strobe, active low |
| cpu_addr | input | 16 | CPU memory address |
| ram_addr | output | 19 | Physical RAM address |
| ram_ce_n | output | 1 | RAM chip enable, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_we_n | output | 1 | RAM write enable, active low |

## Verification
The assertions check on every cycle that the low address bits pass straight through and that each half takes its bank from the correct nibble. They also check that the RAM strobes stay inactive without a memory request, that a load pulse never lasts more than one cycle, and that the register changes only after a load to a matching port. Other behaviour can only be shown by the bench's scenarios. These are the full sweep of 256 register values at the half boundaries and the use of every mirror address. They also include the value the register ends up with after misses at 6FH and 80H, after reads, after a long strobe whose data changes, and after a reset.

// File: rtl/bank_map_pkg.sv
package bank_map_pkg;

    // States of the I/O write strobe edge detector
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_HOLD = 2'd2
    } wr_state_e;

endpackage

// File: rtl/iowr_edge_fsm.sv
module iowr_edge_fsm
    import bank_map_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_async,
    output logic load_pulse
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   strobe_s;
    wr_state_e              state_q;
    wr_state_e              state_d;

    generate
        if (SYNC_STAGES == 1) begin : g_sync_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= strobe_async;
            end
        end else begin : g_sync_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], strobe_async};
            end
        end
    endgenerate

    assign strobe_s = sync_q[SYNC_STAGES-1];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (strobe_s) state_d = ST_LOAD;
            ST_LOAD: state_d = strobe_s ? ST_HOLD : ST_IDLE;
            ST_HOLD: if (!strobe_s) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        load_pulse = 1'b0;
        unique case (state_q)
            ST_LOAD: load_pulse = 1'b1;
            ST_IDLE,
            ST_HOLD: load_pulse = 1'b0;
            default: load_pulse = 1'b0;
        endcase
    end

    // R8: a single load pulse per strobe, never two cycles in a row
    p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load_pulse |=> !load_pulse)
        else $error("load pulse longer than one cycle");

    // R8: once loaded, no new pulse while the strobe is still held
    p_no_repulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |-> !load_pulse)
        else $error("pulse issued while strobe held");

endmodule

// File: rtl/port_match.sv
module port_match #(
    parameter int          IO_AW      = 8,
    parameter logic [7:0]  PORT_MASK  = 8'hF0,
    parameter logic [7:0]  PORT_MATCH = 8'h70
) (
    input  logic [IO_AW-1:0] io_addr,
    output logic             hit
);

    localparam logic [IO_AW-1:0] MASK_W  = IO_AW'(PORT_MASK);
    localparam logic [IO_AW-1:0] MATCH_W = IO_AW'(PORT_MATCH);

    assign hit = ((io_addr & MASK_W) == MATCH_W);

endmodule

// File: rtl/bank_latch.sv
module bank_latch #(
    parameter int BANK_W = 4,
    parameter int HALVES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ld,
    input  logic [HALVES*BANK_W-1:0] d,
    output logic [HALVES*BANK_W-1:0] q
);

    // One nibble per half, deliberately without reset
    for (genvar h = 0; h < HALVES; h++) begin : g_half
        always_ff @(posedge clk) begin
            if (ld) q[h*BANK_W +: BANK_W] <= d[h*BANK_W +: BANK_W];
        end
    end

    // R5: the register holds its value unless a load is issued
    p_hold_no_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && !$isunknown(q)) |=> $stable(q))
        else $error("bank register changed without a load");

endmodule

// File: rtl/addr_xlate.sv
module addr_xlate #(
    parameter int CPU_AW = 16,
    parameter int BANK_W = 4
) (
    input  logic [CPU_AW-1:0]          cpu_addr,
    input  logic [2*BANK_W-1:0]        bank_q,
    input  logic                       mreq_n,
    input  logic                       mem_rd_n,
    input  logic                       mem_wr_n,
    output logic [CPU_AW-2+BANK_W:0]   ram_addr,
    output logic                       ram_ce_n,
    output logic                       ram_oe_n,
    output logic                       ram_we_n
);

    localparam int OFS_W = CPU_AW - 1;

    logic [BANK_W-1:0] bank_sel;

    always_comb begin
        if (cpu_addr[CPU_AW-1]) bank_sel = bank_q[2*BANK_W-1:BANK_W];
        else                    bank_sel = bank_q[BANK_W-1:0];
        ram_addr = {bank_sel, cpu_addr[OFS_W-1:0]};
    end

    always_comb begin
        ram_ce_n = mreq_n;
        ram_oe_n = mreq_n | mem_rd_n;
        ram_we_n = mreq_n | mem_wr_n;
    end

endmodule

// File: rtl/bank_mapper.sv
module bank_mapper #(
    parameter int         CPU_AW      = 16,
    parameter int         BANK_W      = 4,
    parameter int         IO_AW       = 8,
    parameter logic [7:0] PORT_MASK   = 8'hF0,
    parameter logic [7:0] PORT_MATCH  = 8'h70,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          iorq_n,
    input  logic                          io_wr_n,
    input  logic [IO_AW-1:0]              io_addr,
    input  logic [2*BANK_W-1:0]           io_data,
    input  logic                          mreq_n,
    input  logic                          mem_rd_n,
    input  logic                          mem_wr_n,
    input  logic [CPU_AW-1:0]             cpu_addr,
    output logic [CPU_AW-2+BANK_W:0]      ram_addr,
    output logic                          ram_ce_n,
    output logic                          ram_oe_n,
    output logic                          ram_we_n
);

    localparam int REG_W = 2 * BANK_W;
    localparam int OFS_W = CPU_AW - 1;

    logic             strobe_async;
    logic             load_pulse;
    logic             port_hit;
    logic             bank_ld;
    logic [REG_W-1:0] bank_q;

    assign strobe_async = ~iorq_n & ~io_wr_n;

    iowr_edge_fsm #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_edge (
        .clk          (clk),
        .rst_n        (rst_n),
        .strobe_async (strobe_async),
        .load_pulse   (load_pulse)
    );

    port_match #(
        .IO_AW      (IO_AW),
        .PORT_MASK  (PORT_MASK),
        .PORT_MATCH (PORT_MATCH)
    ) u_match (
        .io_addr (io_addr),
        .hit     (port_hit)
    );

    assign bank_ld = load_pulse & port_hit;

    bank_latch #(
        .BANK_W (BANK_W),
        .HALVES (2)
    ) u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .ld    (bank_ld),
        .d     (io_data),
        .q     (bank_q)
    );

    addr_xlate #(
        .CPU_AW (CPU_AW),
        .BANK_W (BANK_W)
    ) u_xlate (
        .cpu_addr (cpu_addr),
        .bank_q   (bank_q),
        .mreq_n   (mreq_n),
        .mem_rd_n (mem_rd_n),
        .mem_wr_n (mem_wr_n),
        .ram_addr (ram_addr),
        .ram_ce_n (ram_ce_n),
        .ram_oe_n (ram_oe_n),
        .ram_we_n (ram_we_n)
    );

    // R1: offset bits pass through unchanged
    p_offset_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ram_addr[OFS_W-1:0] == cpu_addr[OFS_W-1:0])
        else $error("offset bits altered");

    // R2: the lower half takes its bank from the low nibble
    p_low_half_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_addr[CPU_AW-1] && !$isunknown(bank_q))
            |-> ram_addr[OFS_W+BANK_W-1:OFS_W] == bank_q[BANK_W-1:0])
        else $error("lower half bank wrong");

    // R3: the upper half takes its bank from the high nibble
    p_high_half_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[CPU_AW-1] && !$isunknown(bank_q))
            |-> ram_addr[OFS_W+BANK_W-1:OFS_W] == bank_q[REG_W-1:BANK_W])
        else $error("upper half bank wrong");

    // R9: no RAM strobe without a memory request
    p_idle_ram_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mreq_n |-> (ram_ce_n && ram_oe_n && ram_we_n))
        else $error("RAM strobe without memory request");

    // R5: a change of the register follows a load at a matching port
    p_change_needs_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!$isunknown($past(bank_q)) && !$stable(bank_q))
            |-> ($past(load_pulse) && $past(port_hit)))
        else $error("bank register changed without a matching write");

endmodule

// File: tb/tb_bank_mapper.sv
module tb_bank_mapper;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        iorq_n, io_wr_n, mreq_n, mem_rd_n, mem_wr_n;
    logic [7:0]  io_addr, io_data;
    logic [15:0] cpu_addr;
    logic [18:0] ram_addr;
    logic        ram_ce_n, ram_oe_n, ram_we_n;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    bank_mapper dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .iorq_n   (iorq_n),
        .io_wr_n  (io_wr_n),
        .io_addr  (io_addr),
        .io_data  (io_data),
        .mreq_n   (mreq_n),
        .mem_rd_n (mem_rd_n),
        .mem_wr_n (mem_wr_n),
        .cpu_addr (cpu_addr),
        .ram_addr (ram_addr),
        .ram_ce_n (ram_ce_n),
        .ram_oe_n (ram_oe_n),
        .ram_we_n (ram_we_n)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [18:0] map_of(input logic [7:0] v, input logic [15:0] a);
        logic [3:0] b;
        b = a[15] ? v[7:4] : v[3:0];
        return {b, a[14:0]};
    endfunction

    // I/O write held for `hold` cycles, then released and settled
    task automatic io_write(input logic [7:0] port, input logic [7:0] val, input int hold);
        @(negedge clk);
        io_addr = port; io_data = val; iorq_n = 1'b0; io_wr_n = 1'b0;
        repeat (hold) @(negedge clk);
        iorq_n = 1'b1; io_wr_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    // Compare both halves' boundaries against an expected register value
    task automatic probe(input string req, input logic [7:0] v);
        logic [15:0] pts [4];
        pts = '{16'h0000, 16'h7FFF, 16'h8000, 16'hFFFF};
        foreach (pts[i]) begin
            cpu_addr = pts[i];
            #1;
            check(req, 32'(ram_addr), 32'(map_of(v, pts[i])));
        end
    endtask

    task automatic t_reset_state();
        // R9: strobes inactive with no memory request
        #1;
        check("R9 ce idle", 32'(ram_ce_n), 32'd1);
        check("R9 oe idle", 32'(ram_oe_n), 32'd1);
        check("R9 we idle", 32'(ram_we_n), 32'd1);
    endtask

    task automatic t_latency();
        // R4: mapping visible by the fourth edge after the strobe
        io_write(8'h70, 8'h21, 6);
        @(negedge clk);
        io_addr = 8'h7F; io_data = 8'hB4; iorq_n = 1'b0; io_wr_n = 1'b0;
        repeat (4) @(negedge clk);
        probe("R4 latency", 8'hB4);
        iorq_n = 1'b1; io_wr_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_sweep();
        // R2 R3 R4: every value, through all sixteen mirrors
        for (int v = 0; v < 256; v++) begin
            io_write(8'h70 | 8'(v & 15), 8'(v), 5);
            probe("R2/R3 sweep", 8'(v));
        end
    endtask

    task automatic t_identity();
        // R7: 10H maps the first 64KB straight through
        io_write(8'h75, 8'h10, 5);
        for (int a = 0; a < 65536; a += 4099) begin
            cpu_addr = 16'(a);
            #1;
            check("R7 identity", 32'(ram_addr), 32'(a));
        end
        // R1: offset passthrough under a non-trivial map
        io_write(8'h7A, 8'hE3, 5);
        cpu_addr = 16'h5A5A; #1;
        check("R1 offset", 32'(ram_addr[14:0]), 32'h5A5A);
        cpu_addr = 16'hA5A5; #1;
        check("R1 offset", 32'(ram_addr[14:0]), 32'h25A5);
    endtask

    task automatic t_misses();
        // R5: neighbours of the range are ignored
        io_write(8'h73, 8'h96, 5);
        io_write(8'h6F, 8'h11, 5);
        probe("R5 port 6F", 8'h96);
        io_write(8'h80, 8'h22, 5);
        probe("R5 port 80", 8'h96);
        io_write(8'hF7, 8'h33, 5);
        probe("R5 port F7", 8'h96);
    endtask

    task automatic t_read();
        // R6: I/O read to the range does not load
        @(negedge clk);
        io_addr = 8'h78; io_data = 8'h44; iorq_n = 1'b0; io_wr_n = 1'b1;
        repeat (6) @(negedge clk);
        iorq_n = 1'b1;
        repeat (3) @(negedge clk);
        probe("R6 read", 8'h96);
    endtask

    task automatic t_long_strobe();
        // R8: data changing while strobe held does not reload
        @(negedge clk);
        io_addr = 8'h71; io_data = 8'hC7; iorq_n = 1'b0; io_wr_n = 1'b0;
        repeat (5) @(negedge clk);
        io_data = 8'h3D;
        repeat (5) @(negedge clk);
        iorq_n = 1'b1; io_wr_n = 1'b1;
        repeat (3) @(negedge clk);
        probe("R8 single load", 8'hC7);
    endtask

    task automatic t_reset_keeps();
        // R10: reset neither clears the register nor lets writes through
        io_write(8'h7C, 8'h5A, 5);
        @(negedge clk);
        rst_n = 1'b0;
        io_addr = 8'h70; io_data = 8'hCC; iorq_n = 1'b0; io_wr_n = 1'b0;
        repeat (6) @(negedge clk);
        iorq_n = 1'b1; io_wr_n = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        probe("R10 reset", 8'h5A);
    endtask

    task automatic t_mem_strobes();
        // R9: memory strobe passthrough
        mreq_n = 1'b0; mem_rd_n = 1'b0; mem_wr_n = 1'b1; #1;
        check("R9 read ce", 32'(ram_ce_n), 32'd0);
        check("R9 read oe", 32'(ram_oe_n), 32'd0);
        check("R9 read we", 32'(ram_we_n), 32'd1);
        mem_rd_n = 1'b1; mem_wr_n = 1'b0; #1;
        check("R9 write oe", 32'(ram_oe_n), 32'd1);
        check("R9 write we", 32'(ram_we_n), 32'd0);
        mreq_n = 1'b1; mem_rd_n = 1'b0; #1;
        check("R9 no mreq ce", 32'(ram_ce_n), 32'd1);
        check("R9 no mreq oe", 32'(ram_oe_n), 32'd1);
        check("R9 no mreq we", 32'(ram_we_n), 32'd1);
        mem_rd_n = 1'b1; mem_wr_n = 1'b1;
    endtask

    initial begin
        rst_n = 1'b0; iorq_n = 1'b1; io_wr_n = 1'b1;
        mreq_n = 1'b1; mem_rd_n = 1'b1; mem_wr_n = 1'b1;
        io_addr = 8'h00; io_data = 8'h00; cpu_addr = 16'h0000;
        repeat (3) @(negedge clk);
        t_reset_state();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_latency();
        t_sweep();
        t_identity();
        t_misses();
        t_read();
        t_long_strobe();
        t_reset_keeps();
        t_mem_strobes();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule